// File: doc/BRIEF.md
# Multicast hash address filter

This block sits in a receive path and decides whether a frame's 48-bit destination address is one the station wants. Addresses reach it in one of two ways: as a byte stream, first address byte first, under a valid/ready handshake with a last marker, or as a single 48-bit word with a one-cycle valid strobe. The block folds the six address bytes into a reflected CRC-32 and turns part of that CRC into a 6-bit index into a 64-bit hash table. It then sorts the address into one of three classes (own station, group, all-stations) and raises an accept flag.

Software reaches the two hash table words and the two station address words through a small register port. A word write replaces the whole word, so adding a group address means reading the word, setting the bit and writing it back. Two plain configuration pins control the all-stations case and accept-everything mode.

On the stream side, back-pressure works like this. `s_ready` drops only in cycles where `par_valid` is high, because the word port always wins and is taken at once. A stream byte is consumed only in a cycle where both `s_valid` and `s_ready` are high. A stalled stream keeps its partial address and resumes where it left off.

Top module: `mhf_filter`

## Requirements
- R1: `res_index` is derived from the CRC of the six address bytes, taken in order (first address byte first, each byte least significant bit first). The CRC uses the reflected polynomial 0xEDB88320, starts at all ones, and has no final inversion. `res_index[5]` is CRC bit 0, and `res_index[4:0]` are CRC bits 1,2,3,4,5, with bit 1 as the most significant. Put another way, the index is bits 31:26 of the bit-reversed CRC.
- R2: A group address is one whose first byte has bit 0 set and which is not all ones. It is accepted when table bit `res_index[4:0]` is set in the table word chosen by `res_index[5]`: 0 picks register select 0, 1 picks select 1.
- R3: A station address is accepted only when it equals the stored station address. Select 2 holds address bytes 2..5, with byte 2 in bits 31:24 and byte 5 in bits 7:0. Select 3 holds byte 0 in bits 15:8 and byte 1 in bits 7:0; its bits 31:16 are not stored and read as zero.
- R4: The all-ones address is accepted when `cfg_bcast_en` is high and rejected otherwise (unless R5 applies), whatever the hash table holds.
- R5: While `cfg_promisc` is high, every address is accepted.
- R6: On the stream port, `res_valid` pulses in the cycle after the sixth byte is consumed. Bytes after the sixth are consumed and ignored up to and including the byte marked last. The byte after a last byte starts a new address.
- R7: If a byte marked last is consumed before the sixth byte, the partial address is dropped: no result is produced and the next byte starts a new address.
- R8: A `par_valid` strobe is taken in its own cycle, with address byte 0 in `par_addr[47:40]` and byte 5 in `par_addr[7:0]`. Its result appears in the next cycle. `s_ready` is low while `par_valid` is high, and a partly received stream address is held across the stall.
- R9: Register selects 0..3 are written on `reg_wr` with the full word (no merging) and read back combinationally on `reg_rdata`. Reset clears all four to zero.
- R10: `res_kind` is 0 for a station address, 1 for a group address and 2 for the all-ones address. `res_index` reports the hash index for every kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte may be taken |
| s_data | input | 8 | Stream address byte |
| s_last | input | 1 | Final byte of the current stream item |
| par_valid | input | 1 | Whole-address strobe (always taken) |
| par_addr | input | 48 | Whole address, byte 0 in bits 47:40 |
| cfg_bcast_en | input | 1 | Accept the all-ones address |
| cfg_promisc | input | 1 | Accept every address |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0,1 table words; 2,3 station words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| res_valid | output | 1 | Decision strobe |
| res_accept | output | 1 | Address accepted |
| res_kind | output | 2 | Address class |
| res_index | output | 6 | Hash table index |

## Verification
A corrupted CRC accumulator or byte counter shows on the very next decision. It appears either as a wrong `res_index`, or as a decision that arrives a cycle early, a cycle late, or not at all. A counter that fails to clear on a last byte only shows up on the following address: that address gets a wrong index, or a spurious extra result appears. A table or station word stored at the wrong select is visible at once on `reg_rdata`, and it flips the accept flag of the first address that hashes to that word.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = ADDR_BYTES * 8;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned TBL_WORDS  = 2;
  localparam int unsigned SEL_W      = 2;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_SEED      = '1;

  typedef enum logic [1:0] {
    KIND_UCAST = 2'd0,
    KIND_MCAST = 2'd1,
    KIND_BCAST = 2'd2
  } kind_e;

  // Fold one byte, LSB first, into a reflected CRC.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] crc_addr(input logic [ADDR_W-1:0] a);
    logic [CRC_W-1:0] r;
    r = CRC_SEED;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      r = crc_byte(r, a[ADDR_W-1-8*i -: 8]);
    end
    return r;
  endfunction

  // Top six bits of the bit-reversed CRC.
  function automatic logic [IDX_W-1:0] crc_to_index(input logic [CRC_W-1:0] c);
    logic [IDX_W-1:0] x;
    for (int k = 0; k < IDX_W; k++) begin
      x[IDX_W-1-k] = c[k];
    end
    return x;
  endfunction
endpackage

// File: rtl/mhf_regs.sv
module mhf_regs
  import mhf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [SEL_W-1:0]           sel,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          rdata,
  output logic [TBL_WORDS*WORD_W-1:0] table_o,
  output logic [ADDR_W-1:0]          station_o
);
  localparam logic [SEL_W-1:0] SEL_STA_LO = SEL_W'(TBL_WORDS);
  localparam logic [SEL_W-1:0] SEL_STA_HI = SEL_W'(TBL_WORDS + 1);
  localparam int unsigned      HI_W       = ADDR_W - WORD_W;

  logic [WORD_W-1:0] tbl_q [TBL_WORDS];
  logic [WORD_W-1:0] sta_lo_q;
  logic [HI_W-1:0]   sta_hi_q;

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n)                               tbl_q[w] <= '0;
      else if (wr && sel == SEL_W'(w))          tbl_q[w] <= wdata;
    end
    assign table_o[w*WORD_W +: WORD_W] = tbl_q[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
    end else if (wr) begin
      if (sel == SEL_STA_LO) sta_lo_q <= wdata;
      if (sel == SEL_STA_HI) sta_hi_q <= wdata[HI_W-1:0];
    end
  end

  assign station_o = {sta_hi_q, sta_lo_q};

  always_comb begin
    rdata = '0;
    if (sel == SEL_STA_LO)      rdata = sta_lo_q;
    else if (sel == SEL_STA_HI) rdata = {{(WORD_W-HI_W){1'b0}}, sta_hi_q};
    else                        rdata = tbl_q[sel[0]];
  end
endmodule

// File: rtl/mhf_collect.sv
module mhf_collect
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic              hold,
  output logic              s_ready,
  output logic              done,
  output logic [IDX_W-1:0]  idx_fin,
  output logic [ADDR_W-1:0] addr_fin
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_SKIP = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0]    cnt_q;
  logic [CRC_W-1:0]    crc_q;
  logic [ADDR_W-9:0]   addr_q;
  logic [CRC_W-1:0]    crc_step;
  logic                fire;

  assign s_ready  = !hold;
  assign fire     = s_valid && s_ready;
  assign crc_step = crc_byte(crc_q, s_data);
  assign done     = fire && (cnt_q == CNT_LAST);
  assign idx_fin  = crc_to_index(crc_step);
  assign addr_fin = {addr_q, s_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= CRC_SEED;
      addr_q <= '0;
    end else if (fire) begin
      if (cnt_q < CNT_LAST) begin
        if (s_last) begin
          cnt_q <= '0;
          crc_q <= CRC_SEED;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          crc_q  <= crc_step;
          addr_q <= {addr_q[ADDR_W-17:0], s_data};
        end
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= s_last ? '0 : CNT_SKIP;
        crc_q <= CRC_SEED;
      end else if (s_last) begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
(
  input  logic [ADDR_W-1:0]            addr,
  input  logic [IDX_W-1:0]             idx,
  input  logic [TBL_WORDS*WORD_W-1:0]  tbl,
  input  logic [ADDR_W-1:0]            station,
  input  logic                         bcast_en,
  input  logic                         promisc,
  output logic                         accept,
  output kind_e                        kind
);
  logic is_bcast, is_group, hit;

  assign is_bcast = &addr;
  assign is_group = addr[ADDR_W-8];
  assign hit      = tbl[idx];

  always_comb begin
    if (is_bcast) begin
      kind   = KIND_BCAST;
      accept = bcast_en;
    end else if (is_group) begin
      kind   = KIND_MCAST;
      accept = hit;
    end else begin
      kind   = KIND_UCAST;
      accept = (addr == station);
    end
    if (promisc) accept = 1'b1;
  end
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  input  logic        par_valid,
  input  logic [47:0] par_addr,
  input  logic        cfg_bcast_en,
  input  logic        cfg_promisc,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        res_valid,
  output logic        res_accept,
  output logic [1:0]  res_kind,
  output logic [5:0]  res_index
);
  logic [TBL_WORDS*WORD_W-1:0] tbl;
  logic [ADDR_W-1:0]           station;
  logic                        st_done;
  logic [IDX_W-1:0]            st_idx, par_idx, sel_idx;
  logic [ADDR_W-1:0]           st_addr, sel_addr;
  logic                        dec_accept;
  kind_e                       dec_kind;

  mhf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .table_o(tbl), .station_o(station)
  );

  mhf_collect u_collect (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .hold(par_valid), .s_ready(s_ready), .done(st_done),
    .idx_fin(st_idx), .addr_fin(st_addr)
  );

  assign par_idx  = crc_to_index(crc_addr(par_addr));
  assign sel_addr = par_valid ? par_addr : st_addr;
  assign sel_idx  = par_valid ? par_idx  : st_idx;

  mhf_decide u_decide (
    .addr(sel_addr), .idx(sel_idx), .tbl(tbl), .station(station),
    .bcast_en(cfg_bcast_en), .promisc(cfg_promisc),
    .accept(dec_accept), .kind(dec_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_kind   <= KIND_UCAST;
      res_index  <= '0;
    end else begin
      res_valid <= par_valid || st_done;
      if (par_valid || st_done) begin
        res_accept <= dec_accept;
        res_kind   <= dec_kind;
        res_index  <= sel_idx;
      end
    end
  end
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic        par_valid,
  input logic        cfg_bcast_en,
  input logic        cfg_promisc,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_rdata,
  input logic        res_valid,
  input logic        res_accept,
  input logic [1:0]  res_kind
);
  // R8
  par_stalls_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> !s_ready);

  // R8
  par_result_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |=> res_valid);

  // R6
  result_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(par_valid || (s_valid && s_ready)));

  // R5
  promisc_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cfg_promisc)) |-> res_accept);

  // R4
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd2 && !$past(cfg_bcast_en) && !$past(cfg_promisc))
      |-> !res_accept);

  // R9
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && $stable(reg_sel)) |-> $stable(reg_rdata));
endmodule

bind mhf_filter mhf_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .par_valid(par_valid), .cfg_bcast_en(cfg_bcast_en), .cfg_promisc(cfg_promisc),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .res_valid(res_valid), .res_accept(res_accept), .res_kind(res_kind)
);

// File: tb/tb_mhf_filter.sv
`timescale 1ns/1ps
module tb_mhf_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        par_valid = 1'b0;
  logic [47:0] par_addr = '0;
  logic        cfg_bcast_en = 1'b0, cfg_promisc = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        res_valid, res_accept;
  logic [1:0]  res_kind;
  logic [5:0]  res_index;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_tbl [2];
  logic [31:0] m_sta_lo = '0;
  logic [15:0] m_sta_hi = '0;

  logic [1:0]  q_kind [$];
  logic [5:0]  q_idx  [$];
  logic        q_acc  [$];
  string       q_tag  [$];

  always #5 clk = ~clk;

  mhf_filter dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .par_valid(par_valid), .par_addr(par_addr),
    .cfg_bcast_en(cfg_bcast_en), .cfg_promisc(cfg_promisc), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .res_valid(res_valid), .res_accept(res_accept), .res_kind(res_kind),
    .res_index(res_index)
  );

  // Bench model of the hash: bit-serial reflected CRC, then full reversal.
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c, h;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ a[47 - 8*i - 7 + b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    for (int k = 0; k < 32; k++) h[31-k] = c[k];
    return h[31:26];
  endfunction

  task automatic push_exp(input logic [47:0] a, input string tag);
    logic [5:0] ix;
    logic [1:0] kd;
    logic       ac;
    ix = ref_index(a);
    if (a == 48'hFFFF_FFFF_FFFF) begin kd = 2'd2; ac = cfg_bcast_en; end
    else if (a[40]) begin kd = 2'd1; ac = m_tbl[ix[5]][ix[4:0]]; end
    else begin kd = 2'd0; ac = (a == {m_sta_hi, m_sta_lo}); end
    if (cfg_promisc) ac = 1'b1;
    q_kind.push_back(kd); q_idx.push_back(ix); q_acc.push_back(ac); q_tag.push_back(tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      n_vec++;
      if (q_kind.size() == 0) begin
        n_bad++;
        $display("FAIL R6/R7 unexpected result: got kind=%0d idx=%0d acc=%0b, expected none",
                 res_kind, res_index, res_accept);
      end else begin
        logic [1:0] ek; logic [5:0] ei; logic ea; string et;
        ek = q_kind.pop_front(); ei = q_idx.pop_front();
        ea = q_acc.pop_front();  et = q_tag.pop_front();
        if (res_kind !== ek || res_index !== ei || res_accept !== ea) begin
          n_bad++;
          $display("FAIL %s: got kind=%0d idx=%0d acc=%0b, expected kind=%0d idx=%0d acc=%0b",
                   et, res_kind, res_index, res_accept, ek, ei, ea);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h, expected %h", tag, got, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last, input bit fin,
                           input logic [47:0] a, input string tag);
    s_valid = 1'b1; s_data = b; s_last = last;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    if (fin) push_exp(a, tag);
    @(posedge clk); #1;
  endtask

  task automatic stream_addr(input logic [47:0] a, input int extra, input string tag);
    for (int i = 0; i < 6 + extra; i++) begin
      logic [7:0] b;
      b = (i < 6) ? a[47 - 8*i -: 8] : 8'(8'hA0 + i);
      send_byte(b, i == 5 + extra, i == 5, a, tag);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic stream_short(input logic [47:0] a, input int n);
    for (int i = 0; i < n; i++) send_byte(a[47 - 8*i -: 8], i == n - 1, 1'b0, a, "R7");
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic par_send(input logic [47:0] a, input string tag);
    par_valid = 1'b1; par_addr = a;
    push_exp(a, tag);
    #1 check(s_ready == 1'b0, "R8 s_ready during par_valid", {31'd0, s_ready}, 32'd0);
    @(posedge clk); #1;
    par_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    case (sel)
      2'd0: m_tbl[0] = d;
      2'd1: m_tbl[1] = d;
      2'd2: m_sta_lo = d;
      default: m_sta_hi = d[15:0];
    endcase
  endtask

  task automatic rd_check(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    reg_sel = sel; #1;
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Add a group address the way software does: read, OR, write.
  task automatic add_group(input logic [47:0] a);
    logic [5:0] ix;
    logic [31:0] w;
    ix = ref_index(a);
    reg_sel = {1'b0, ix[5]}; #1;
    w = reg_rdata | (32'd1 << ix[4:0]);
    wr_reg({1'b0, ix[5]}, w);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] sta, g1, g2;
    m_tbl[0] = '0; m_tbl[1] = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    #1;
    // Reset state (R9)
    check(res_valid == 1'b0, "R9 reset res_valid", {31'd0, res_valid}, 32'd0);
    check(s_ready == 1'b1, "R8 reset s_ready", {31'd0, s_ready}, 32'd1);
    for (int s = 0; s < 4; s++) rd_check(2'(s), 32'd0, "R9 reset register");

    // Station address 02-11-22-33-44-55 (R3, R9)
    sta = 48'h0211_2233_4455;
    wr_reg(2'd2, 32'h2233_4455);
    wr_reg(2'd3, 32'hFFFF_0211);
    rd_check(2'd2, 32'h2233_4455, "R3 station low word");
    rd_check(2'd3, 32'h0000_0211, "R3 station high word upper bits zero");
    rd_check(2'd0, 32'd0, "R9 table word 0 untouched");

    // Station addresses (R3, R1, R10)
    stream_addr(sta, 0, "R3 station match");
    stream_addr(48'h0211_2233_4456, 0, "R3 last byte mismatch");
    stream_addr(48'h0611_2233_4455, 0, "R3 first byte mismatch");
    idle(2);

    // Group addresses, empty table then one added bit (R2)
    g1 = 48'h0100_5E00_0001;
    g2 = 48'h0100_5E00_0002;
    stream_addr(g1, 0, "R2 group empty table");
    idle(2);
    add_group(g1);
    stream_addr(g1, 0, "R2 group after add");
    stream_addr(g2, 0, "R2 other group");
    idle(2);

    // Pattern table, many group addresses, both ports (R1, R2, R8)
    wr_reg(2'd0, 32'hA5A5_0F0F);
    wr_reg(2'd1, 32'h3C3C_F00F);
    rd_check(2'd1, 32'h3C3C_F00F, "R9 table word 1 replace");
    for (int k = 0; k < 10; k++) begin
      logic [47:0] a;
      a = {8'h01 + 8'(2*k), 8'h00, 8'h5E, 8'(k * 37), 8'(k * 11 + 3), 8'(k)};
      stream_addr(a, 0, "R1 R2 stream group");
      par_send(a, "R1 R8 parallel group");
    end
    idle(2);

    // All-ones address (R4)
    stream_addr(48'hFFFF_FFFF_FFFF, 0, "R4 bcast disabled");
    idle(1); wr_reg(2'd0, 32'hFFFF_FFFF); wr_reg(2'd1, 32'hFFFF_FFFF);
    stream_addr(48'hFFFF_FFFF_FFFF, 0, "R4 bcast disabled full table");
    idle(2); cfg_bcast_en = 1'b1;
    stream_addr(48'hFFFF_FFFF_FFFF, 0, "R4 bcast enabled");
    par_send(48'hFFFF_FFFF_FFFF, "R4 bcast enabled parallel");
    idle(2); cfg_bcast_en = 1'b0;

    // Promiscuous (R5)
    wr_reg(2'd0, 32'd0); wr_reg(2'd1, 32'd0);
    idle(1); cfg_promisc = 1'b1;
    stream_addr(48'h0211_2233_4499, 0, "R5 promisc station mismatch");
    stream_addr(g2, 0, "R5 promisc group empty table");
    par_send(48'hFFFF_FFFF_FFFF, "R5 promisc bcast disabled");
    idle(2); cfg_promisc = 1'b0;

    // Extra bytes ignored, back-to-back (R6)
    stream_addr(sta, 3, "R6 extra bytes skipped");
    stream_addr(g1, 0, "R6 next address after skip");
    stream_addr(g2, 1, "R6 one extra byte");
    idle(3);

    // Short item dropped (R7)
    stream_short(g2, 3);
    stream_addr(sta, 0, "R7 full address after short");
    stream_short(sta, 5);
    stream_addr(g1, 0, "R7 full address after five-byte short");
    idle(3);

    // Parallel strobe in the middle of a stream address (R8)
    fork
      stream_addr(sta, 0, "R8 stalled stream resumes");
      begin
        repeat (2) @(posedge clk);
        #1 par_send(g1, "R8 parallel during stream");
      end
    join
    par_send(g2, "R8 back-to-back parallel 1");
    par_send(sta, "R8 back-to-back parallel 2");
    idle(4);

    check(q_kind.size() == 0, "R6 R7 pending expected results", 32'(q_kind.size()), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule